// File: doc/BRIEF.md
# Floating-Point Exception Status Tracker

This block keeps the status word of one floating-point arithmetic unit, together with the trap-enable and mode control word that goes with it. The arithmetic datapath signals the start and end of each operation. At the end of an operation it presents the raw exception vector. A qualifier says whether the current operation is one that can raise exceptions. The block clears the per-operation flags when such an operation starts and collects the raw flags when it ends. At the same time it folds a fixed logical combination of those flags into a sticky accrued byte. It also holds the quotient byte and the condition-code nibble, which the datapath loads through their own strobes.

Software reads the status word and the control word and can overwrite either one. A null-restore strobe brings the accrued byte and the control word back to their defaults. A per-class trap request is formed from the per-operation flags and the enable byte of the control word. The accrued byte has no part in forming it. The block does no arithmetic, no rounding and no exception vectoring.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset, `status_word`, `ctrl_word` and `trap_req` are all zero.
- R2: When `op_start` and `op_raises` are both high, the per-operation flags (status bits 15..8) are cleared. When `op_start` is high with `op_raises` low, the flags are left unchanged.
- R3: When `op_end` and `op_raises` are both high, `op_exc` is ORed into the per-operation flags. These flags sit in status bits 15..8, ordered from bit 15 down as branch-on-unordered, signaling NaN, operand error, overflow, underflow, divide by zero, inexact-2, inexact-1. `op_exc` uses the same order in its bits 7..0. If the operation also starts in that cycle, the flags become exactly `op_exc`.
- R4: The accrued byte sits in status bits 7..3, ordered from bit 7 down as invalid, overflow, underflow, divide by zero, inexact. Bits 2..0 read as zero. At a qualifying operation end the bits are ORed with values computed from the new per-operation flags: invalid = SNaN | operand error; overflow = overflow; underflow = underflow & inexact-2; divide by zero = divide by zero; inexact = inexact-1 | inexact-2 | overflow. When `op_end` is high with `op_raises` low, nothing accrues.
- R5: `quot_we` loads `quot_in` into status bits 23..16. Bit 23 is the quotient sign and bits 22..16 are the low seven quotient bits. The byte holds its value otherwise.
- R6: `cc_we` loads `cc_in` into status bits 27..24, ordered from bit 27 down as negative, zero, infinity, NaN. The nibble changes on no other hardware event. Status bits 31..28 read as zero.
- R7: `trap_req[i]` is per-operation flag i ANDed with control bit 8+i. Accrued bits never raise or mask a trap.
- R8: `null_restore` clears the accrued byte and the control word in the next cycle. It leaves the per-operation flags, the quotient byte and the condition nibble unchanged.
- R9: `sw_ctrl_we` loads `sw_wdata[15:0]` into the control word. Bits 15..8 are the trap enable byte and bits 7..0 the mode byte. Control bits 31..16 read as zero and ignore writes.
- R10: `sw_status_we` loads bits 27..24, 23..16, 15..8 and 7..3 of `sw_wdata` into the status word. In the same cycle it takes priority over `op_start`, `op_end`, `quot_we` and `cc_we`.
- R11: When `null_restore` and a software write happen in the same cycle, the accrued byte and the control word still come out zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| null_restore | input | 1 | Return accrued byte and control word to defaults |
| op_start | input | 1 | Operation begins |
| op_end | input | 1 | Operation completes, `op_exc` valid |
| op_raises | input | 1 | Current operation can raise exceptions |
| op_exc | input | 8 | Raw exception flags of the completing operation |
| quot_we | input | 1 | Load quotient byte |
| quot_in | input | 8 | Quotient sign and low seven bits |
| cc_we | input | 1 | Load condition nibble |
| cc_in | input | 4 | Condition nibble N, Z, I, NaN |
| sw_status_we | input | 1 | Software write of the status word |
| sw_ctrl_we | input | 1 | Software write of the control word |
| sw_wdata | input | 32 | Software write data |
| status_word | output | 32 | Status word |
| ctrl_word | output | 32 | Control word, upper half zero |
| trap_req | output | 8 | Per-class trap request |

## Verification
The hardest case to reach is a cycle in which an operation starts, ends and accrues, and software overwrites the status word in that same cycle. A second hard case is a cycle in which a null restore collides with a software write. Uniform stimulus rarely lines these strobes up. For that reason the random phase raises the strobe probabilities so that such overlaps happen often, and directed steps force each collision at least once. Underflow accrual depends on two flags together. The directed steps therefore present underflow alone and then underflow with inexact-2, so the AND in that mapping is observed in both outcomes.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W  = 8;
  localparam int ACC_W  = 5;
  localparam int QUOT_W = 8;
  localparam int CC_W   = 4;
  localparam int CTRL_W = 16;
  localparam int WORD_W = 32;

  // field positions inside the status word
  localparam int ACC_LSB  = 3;
  localparam int EXC_LSB  = 8;
  localparam int QUOT_LSB = 16;
  localparam int CC_LSB   = 24;

  // flag positions inside the per-operation byte
  localparam int F_BSUN  = 7;
  localparam int F_SNAN  = 6;
  localparam int F_OPERR = 5;
  localparam int F_OVFL  = 4;
  localparam int F_UNFL  = 3;
  localparam int F_DZ    = 2;
  localparam int F_INEX2 = 1;
  localparam int F_INEX1 = 0;

  // positions inside the accrued field
  localparam int A_IOP  = 4;
  localparam int A_OVFL = 3;
  localparam int A_UNFL = 2;
  localparam int A_DZ   = 1;
  localparam int A_INEX = 0;

  typedef logic [EXC_W-1:0] exc_t;
  typedef logic [ACC_W-1:0] acc_t;

  // sticky contribution of one set of per-operation flags
  function automatic acc_t accrue_map(input exc_t e);
    acc_t a;
    a         = '0;
    a[A_IOP]  = e[F_SNAN] | e[F_OPERR];
    a[A_OVFL] = e[F_OVFL];
    a[A_UNFL] = e[F_UNFL] & e[F_INEX2];
    a[A_DZ]   = e[F_DZ];
    a[A_INEX] = e[F_INEX1] | e[F_INEX2] | e[F_OVFL];
    return a;
  endfunction

  // per-operation flags after a start and/or end event
  function automatic exc_t exc_step(input exc_t cur, input logic clr,
                                    input logic ld, input exc_t raw);
    exc_t base;
    base = clr ? '0 : cur;
    return ld ? (base | raw) : base;
  endfunction
endpackage

// File: rtl/fpx_exc_track.sv
module fpx_exc_track
  import fpx_pkg::*;
#(
  parameter int XW = EXC_W,
  parameter int AW = ACC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_acc,
  input  logic          op_start,
  input  logic          op_end,
  input  logic          op_raises,
  input  logic [XW-1:0] op_exc,
  input  logic          sw_we,
  input  logic [XW-1:0] sw_exc,
  input  logic [AW-1:0] sw_acc,
  output logic [XW-1:0] exc_q,
  output logic [AW-1:0] acc_q
);
  // named internal events
  logic          ev_clear;
  logic          ev_load;
  logic [XW-1:0] exc_nx;
  logic [AW-1:0] acc_add;

  assign ev_clear = op_start & op_raises;
  assign ev_load  = op_end & op_raises;
  assign exc_nx   = exc_step(exc_q, ev_clear, ev_load, op_exc);
  assign acc_add  = ev_load ? accrue_map(exc_nx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q <= '0;
    end else if (sw_we) begin
      exc_q <= sw_exc;
    end else begin
      exc_q <= exc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr_acc) begin
      acc_q <= '0;
    end else if (sw_we) begin
      acc_q <= sw_acc;
    end else begin
      acc_q <= acc_q | acc_add;
    end
  end

  assert_exc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_clear && !ev_load && !sw_we) |=> $stable(exc_q));

  assert_acc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !clr_acc) |=> (($past(acc_q) & ~acc_q) == '0));

  assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (acc_q == '0));

  assert_sw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (exc_q == $past(sw_exc)));
endmodule

// File: rtl/fpx_qcc_reg.sv
module fpx_qcc_reg
  import fpx_pkg::*;
#(
  parameter int QW = QUOT_W,
  parameter int CW = CC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          quot_we,
  input  logic [QW-1:0] quot_in,
  input  logic          cc_we,
  input  logic [CW-1:0] cc_in,
  input  logic          sw_we,
  input  logic [QW-1:0] sw_quot,
  input  logic [CW-1:0] sw_cc,
  output logic [QW-1:0] quot_q,
  output logic [CW-1:0] cc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot_q <= '0;
      cc_q   <= '0;
    end else if (sw_we) begin
      quot_q <= sw_quot;
      cc_q   <= sw_cc;
    end else begin
      if (quot_we) quot_q <= quot_in;
      if (cc_we)   cc_q   <= cc_in;
    end
  end

  assert_cc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_we && !sw_we) |=> $stable(cc_q));

  assert_quot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!quot_we && !sw_we) |=> $stable(quot_q));
endmodule

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
  import fpx_pkg::*;
#(
  parameter int KW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [KW-1:0] wdata,
  output logic [KW-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl_q <= '0;
    else if (clr) ctrl_q <= '0;
    else if (we)  ctrl_q <= wdata;
  end

  assert_ctrl_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctrl_q == '0));

  assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int XW = EXC_W,
  parameter int AW = ACC_W,
  parameter int QW = QUOT_W,
  parameter int CW = CC_W,
  parameter int KW = CTRL_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          null_restore,
  input  logic          op_start,
  input  logic          op_end,
  input  logic          op_raises,
  input  logic [XW-1:0] op_exc,
  input  logic          quot_we,
  input  logic [QW-1:0] quot_in,
  input  logic          cc_we,
  input  logic [CW-1:0] cc_in,
  input  logic          sw_status_we,
  input  logic          sw_ctrl_we,
  input  logic [WW-1:0] sw_wdata,
  output logic [WW-1:0] status_word,
  output logic [WW-1:0] ctrl_word,
  output logic [XW-1:0] trap_req
);
  localparam int EN_LSB = KW - XW;
  localparam int TOP_W  = WW - CC_LSB - CW;

  logic [XW-1:0] exc_q;
  logic [AW-1:0] acc_q;
  logic [QW-1:0] quot_q;
  logic [CW-1:0] cc_q;
  logic [KW-1:0] ctrl_q;
  logic [XW-1:0] enable_byte;

  fpx_exc_track #(.XW(XW), .AW(AW)) u_exc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_acc   (null_restore),
    .op_start  (op_start),
    .op_end    (op_end),
    .op_raises (op_raises),
    .op_exc    (op_exc),
    .sw_we     (sw_status_we),
    .sw_exc    (sw_wdata[EXC_LSB +: XW]),
    .sw_acc    (sw_wdata[ACC_LSB +: AW]),
    .exc_q     (exc_q),
    .acc_q     (acc_q)
  );

  fpx_qcc_reg #(.QW(QW), .CW(CW)) u_qcc (
    .clk     (clk),
    .rst_n   (rst_n),
    .quot_we (quot_we),
    .quot_in (quot_in),
    .cc_we   (cc_we),
    .cc_in   (cc_in),
    .sw_we   (sw_status_we),
    .sw_quot (sw_wdata[QUOT_LSB +: QW]),
    .sw_cc   (sw_wdata[CC_LSB +: CW]),
    .quot_q  (quot_q),
    .cc_q    (cc_q)
  );

  fpx_ctrl_reg #(.KW(KW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (null_restore),
    .we     (sw_ctrl_we),
    .wdata  (sw_wdata[KW-1:0]),
    .ctrl_q (ctrl_q)
  );

  assign enable_byte = ctrl_q[EN_LSB +: XW];

  // one gate per exception class
  for (genvar g = 0; g < XW; g++) begin : g_trap
    assign trap_req[g] = exc_q[g] & enable_byte[g];
  end

  assign status_word = {{TOP_W{1'b0}}, cc_q, quot_q, exc_q, acc_q, {ACC_LSB{1'b0}}};
  assign ctrl_word   = {{(WW-KW){1'b0}}, ctrl_q};

  assert_trap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    null_restore |=> (trap_req == '0));

  assert_top_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[WW-1:KW] == '0);
endmodule

// File: tb/fpx_status_unit_tb_top.sv
module fpx_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        null_restore = 1'b0;
  logic        op_start = 1'b0, op_end = 1'b0, op_raises = 1'b0;
  logic [7:0]  op_exc = '0;
  logic        quot_we = 1'b0;
  logic [7:0]  quot_in = '0;
  logic        cc_we = 1'b0;
  logic [3:0]  cc_in = '0;
  logic        sw_status_we = 1'b0, sw_ctrl_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] status_word, ctrl_word;
  logic [7:0]  trap_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [7:0]  m_exc = '0;
  logic [4:0]  m_acc = '0;
  logic [7:0]  m_quot = '0;
  logic [3:0]  m_cc = '0;
  logic [15:0] m_ctrl = '0;

  always #5 clk = ~clk;

  fpx_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .null_restore(null_restore),
    .op_start(op_start), .op_end(op_end), .op_raises(op_raises), .op_exc(op_exc),
    .quot_we(quot_we), .quot_in(quot_in), .cc_we(cc_we), .cc_in(cc_in),
    .sw_status_we(sw_status_we), .sw_ctrl_we(sw_ctrl_we), .sw_wdata(sw_wdata),
    .status_word(status_word), .ctrl_word(ctrl_word), .trap_req(trap_req)
  );

  // accrued contribution, written bit by bit from R4
  function automatic logic [4:0] sticky_of(input logic [7:0] f);
    logic iv, ov, un, dz, ix;
    iv = f[6] | f[5];
    ov = f[4];
    un = f[3] & f[1];
    dz = f[2];
    ix = f[0] | f[1] | f[4];
    return {iv, ov, un, dz, ix};
  endfunction

  function automatic logic [31:0] exp_status();
    return {4'h0, m_cc, m_quot, m_exc, m_acc, 3'b000};
  endfunction

  task automatic model_update();
    logic [7:0] nx;
    if (sw_status_we) begin
      m_exc  = sw_wdata[15:8];
      m_acc  = sw_wdata[7:3];
      m_quot = sw_wdata[23:16];
      m_cc   = sw_wdata[27:24];
    end else begin
      nx = m_exc;
      if (op_start && op_raises) nx = 8'h00;
      if (op_end && op_raises) begin
        nx    = nx | op_exc;
        m_acc = m_acc | sticky_of(nx);
      end
      m_exc = nx;
      if (quot_we) m_quot = quot_in;
      if (cc_we)   m_cc = cc_in;
    end
    if (sw_ctrl_we) m_ctrl = sw_wdata[15:0];
    if (null_restore) begin
      m_acc  = '0;
      m_ctrl = '0;
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] es, ec;
    logic [7:0]  et;
    es = exp_status();
    ec = {16'h0000, m_ctrl};
    et = m_exc & m_ctrl[15:8];
    checks++;
    if (status_word !== es || ctrl_word !== ec || trap_req !== et) begin
      errors++;
      $display("FAIL %s status=%08h exp=%08h ctrl=%08h exp=%08h trap=%02h exp=%02h",
               tag, status_word, es, ctrl_word, ec, trap_req, et);
    end
  endtask

  task automatic idle();
    null_restore = 0; op_start = 0; op_end = 0; op_raises = 0; op_exc = '0;
    quot_we = 0; cc_we = 0; sw_status_we = 0; sw_ctrl_we = 0;
  endtask

  // inputs already set; advance one edge and compare
  task automatic step(input string tag);
    model_update();
    @(posedge clk);
    #1;
    compare(tag);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    idle();
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    rst_n = 1;
    @(posedge clk); #1;
    compare("R1 after release");

    // R9: control write, upper half ignored
    sw_ctrl_we = 1; sw_wdata = 32'hFFFF_FF3C; step("R9 ctrl write");

    // R3: start then end
    op_start = 1; op_raises = 1; step("R2 start clears");
    op_end = 1; op_raises = 1; op_exc = 8'h41; step("R3 end loads flags");
    // R7: SNAN and INEX1 both enabled (0xFF) -> trap
    op_start = 1; op_raises = 0; step("R2 non-raising start keeps flags");
    // R4: underflow alone does not accrue underflow
    op_start = 1; op_end = 1; op_raises = 1; op_exc = 8'h08; step("R4 unfl alone");
    op_start = 1; op_end = 1; op_raises = 1; op_exc = 8'h0A; step("R4 unfl with inex2");
    op_end = 1; op_raises = 0; op_exc = 8'hFF; step("R4 move does not accrue");
    op_start = 1; op_end = 1; op_raises = 1; op_exc = 8'h34; step("R4 operr ovfl dz");

    // R7: accrued set but flags clear -> no trap
    sw_status_we = 1; sw_wdata = 32'h0000_00F8; step("R7 accrued does not trap");
    sw_ctrl_we = 1; sw_wdata = 32'h0000_1400; step("R9 partial enable");
    sw_status_we = 1; sw_wdata = 32'h0000_FF00; step("R7 enable mask");

    // R5 R6
    quot_we = 1; quot_in = 8'hA7; step("R5 quotient load");
    op_start = 1; op_end = 1; op_raises = 1; op_exc = 8'h02; step("R5 quotient held");
    cc_we = 1; cc_in = 4'h9; step("R6 cc load");
    quot_we = 1; quot_in = 8'h11; step("R6 cc held on quotient load");

    // R10: software write collides with hardware events
    sw_status_we = 1; sw_wdata = 32'hF5A3_C3F8;
    op_start = 1; op_end = 1; op_raises = 1; op_exc = 8'hFF;
    quot_we = 1; quot_in = 8'h00; cc_we = 1; cc_in = 4'h0;
    step("R10 software wins");

    // R8: null restore
    op_start = 1; op_end = 1; op_raises = 1; op_exc = 8'h7F; step("R8 prepare");
    sw_ctrl_we = 1; sw_wdata = 32'h0000_FFFF; step("R8 prepare ctrl");
    null_restore = 1; step("R8 null restore");
    // R11: null restore over software writes
    sw_ctrl_we = 1; sw_status_we = 1; sw_wdata = 32'h0FFF_FFFF; null_restore = 1;
    step("R11 restore beats write");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      op_start     = ($urandom % 3) == 0;
      op_end       = ($urandom % 3) == 0;
      op_raises    = ($urandom % 4) != 0;
      op_exc       = 8'($urandom);
      quot_we      = ($urandom % 5) == 0;
      quot_in      = 8'($urandom);
      cc_we        = ($urandom % 5) == 0;
      cc_in        = 4'($urandom);
      sw_status_we = ($urandom % 11) == 0;
      sw_ctrl_we   = ($urandom % 9) == 0;
      sw_wdata     = $urandom;
      null_restore = ($urandom % 23) == 0;
      step("R3 R4 R10 random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule